// File: doc/BRIEF.md
# Z80 Bus Memory and I/O Select Decoder

This block turns the address and control strobes of a Z80-style processor bus into device selects. A memory cycle uses the upper address bits to pick the boot ROM, the working RAM, or one of two requests toward a slave processor. The first slave request covers a shared-RAM region. The second covers a small peripheral window. An I/O cycle uses address bits 7 to 5 to pick three input ports, a UART, or a write-only control port. The selects are mostly active-low, but input port 3 and the control strobe are active-high.

A write to the control port loads a small register on the system clock. The register drives three active-low system lines: a sync line, an audio mute and a slave-processor reset. It also holds a two-bit code for a two-colour LED. Reset clears the register. This keeps the mute and the slave reset asserted, and the LED dark, until software writes the port.

Top module: `z80_bus_decoder`

## Requirements
- R1: The memory selects (rom_sel_n, ram_sel_n, shram_req_n, perif_req_n) go active only while mreq_n is low and iorq_n is high. At all other times all four stay high.
- R2: During a memory cycle, addresses 0000h to 7FFFh drive rom_sel_n low.
- R3: During a memory cycle, addresses A000h to BFFFh drive ram_sel_n low.
- R4: During a memory cycle, addresses C000h to DFFFh drive shram_req_n low.
- R5: During a memory cycle, addresses E000h to E3FFh drive perif_req_n low. Addresses 8000h to 9FFFh and E400h to FFFFh select no memory device.
- R6: The I/O selects go active only while iorq_n is low and mreq_n is high. Only addr[7:5] is decoded, so each port repeats through its 32-byte block and addr[15:8] has no effect.
- R7: In an I/O cycle with rd_n low, code 000 drives in1_sel_n low, code 001 drives in2_sel_n low, and code 010 drives in3_sel high. With rd_n high, none of these three is active.
- R8: In an I/O cycle, code 100 drives uart_sel_n low whenever rd_n or wr_n is low.
- R9: ctl_wr is high exactly while iorq_n, wr_n and mreq_n are low/low/high and the code is 011. A read of code 011 activates no select.
- R10: At a clock edge where ctl_wr is high and it was low at the previous edge, the register loads din[4:0]. After that edge, sync_n shows bit 0, mute_n bit 1, slave_rst_n bit 2 and led_code bits 4:3. At every other edge the register holds, including while the strobe stays high.
- R11: led_green is high only for led_code 01, and led_red is high only for led_code 10. Codes 00 and 11 light neither.
- R12: While rst_n is low, the register clears. sync_n, mute_n and slave_rst_n read low, led_code reads 00, and both LED outputs read low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| din | input | 8 | Processor data bus, as seen on writes |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rom_sel_n | output | 1 | ROM select, active low |
| ram_sel_n | output | 1 | RAM select, active low |
| shram_req_n | output | 1 | Slave shared-RAM request, active low |
| perif_req_n | output | 1 | Slave peripheral request, active low |
| in1_sel_n | output | 1 | Input port 1 select, active low |
| in2_sel_n | output | 1 | Input port 2 select, active low |
| in3_sel | output | 1 | Input port 3 select, active high |
| uart_sel_n | output | 1 | UART select, active low |
| ctl_wr | output | 1 | Control port write strobe, active high |
| sync_n | output | 1 | Latched sync line |
| mute_n | output | 1 | Latched mute line |
| slave_rst_n | output | 1 | Latched slave reset line |
| led_code | output | 2 | Latched LED colour code |
| led_green | output | 1 | LED green drive |
| led_red | output | 1 | LED red drive |

## Verification
The one-hot assertion over every select assumes the bus never asserts mreq_n and iorq_n together. The decoder still keeps quiet in that case, so random cycles that lower both strobes are still allowed, and they only confirm that nothing fires. The register assertions assume reset is held across at least one clock edge, which the bench does before any bus activity. The random stimulus weights addresses toward the region and port boundaries. It also holds the control strobe for several cycles while the data changes, so that a held strobe is seen to load only once.

// File: rtl/z80_bus_decoder.sv
module z80_bus_decoder #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          mreq_n,
  input  logic          iorq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  output logic          rom_sel_n,
  output logic          ram_sel_n,
  output logic          shram_req_n,
  output logic          perif_req_n,
  output logic          in1_sel_n,
  output logic          in2_sel_n,
  output logic          in3_sel,
  output logic          uart_sel_n,
  output logic          ctl_wr,
  output logic          sync_n,
  output logic          mute_n,
  output logic          slave_rst_n,
  output logic [1:0]    led_code,
  output logic          led_green,
  output logic          led_red
);

  localparam logic [2:0] P_IN1  = 3'b000;
  localparam logic [2:0] P_IN2  = 3'b001;
  localparam logic [2:0] P_IN3  = 3'b010;
  localparam logic [2:0] P_CTL  = 3'b011;
  localparam logic [2:0] P_UART = 3'b100;
  localparam int         CW     = 5;

  logic          mem_cyc, io_cyc;
  logic [2:0]    hi3, port;
  logic          perif_win;
  logic [CW-1:0] ctl_q;
  logic          wr_prev;

  assign mem_cyc = !mreq_n && iorq_n;
  assign io_cyc  = !iorq_n && mreq_n;
  assign hi3     = addr[AW-1 -: 3];
  assign port    = addr[7:5];
  assign perif_win = (hi3 == 3'b111) && (addr[AW-4 -: 3] == 3'b000);

  assign rom_sel_n   = !(mem_cyc && !hi3[2]);
  assign ram_sel_n   = !(mem_cyc && hi3 == 3'b101);
  assign shram_req_n = !(mem_cyc && hi3 == 3'b110);
  assign perif_req_n = !(mem_cyc && perif_win);

  assign in1_sel_n  = !(io_cyc && !rd_n && port == P_IN1);
  assign in2_sel_n  = !(io_cyc && !rd_n && port == P_IN2);
  assign in3_sel    =   io_cyc && !rd_n && port == P_IN3;
  assign uart_sel_n = !(io_cyc && (!rd_n || !wr_n) && port == P_UART);
  assign ctl_wr     =   io_cyc && !wr_n && port == P_CTL;

  always_ff @(posedge clk) wr_prev <= ctl_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 ctl_q <= '0;
    else if (ctl_wr && !wr_prev) ctl_q <= din[CW-1:0];

  assign sync_n      = ctl_q[0];
  assign mute_n      = ctl_q[1];
  assign slave_rst_n = ctl_q[2];
  assign led_code    = ctl_q[4:3];
  assign led_green   = led_code == 2'b01;
  assign led_red     = led_code == 2'b10;

  // R1 R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!rom_sel_n, !ram_sel_n, !shram_req_n, !perif_req_n,
              !in1_sel_n, !in2_sel_n, in3_sel, !uart_sel_n, ctl_wr}));

  // R1
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_n || !iorq_n) |-> &{rom_sel_n, ram_sel_n, shram_req_n, perif_req_n});

  // R2
  rom_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_sel_n |-> (addr < 16'h8000));

  // R5
  perif_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !perif_req_n |-> (addr >= 16'hE000 && addr <= 16'hE3FF));

  // R7
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in1_sel_n || !in2_sel_n || in3_sel) |-> (!rd_n && !iorq_n));

  // R9
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |-> (!wr_n && !iorq_n && mreq_n));

  // R10
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_wr) |=> {led_code, slave_rst_n, mute_n, sync_n} == $past(din[4:0]));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ctl_wr) |=> $stable({led_code, slave_rst_n, mute_n, sync_n}));

  // R11
  led_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(led_green && led_red));

endmodule

// File: tb/sim_z80_bus_decoder.sv
module sim_z80_bus_decoder;
  logic clk = 0, rst_n = 0;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic mreq_n = 1, iorq_n = 1, rd_n = 1, wr_n = 1;
  logic rom_sel_n, ram_sel_n, shram_req_n, perif_req_n;
  logic in1_sel_n, in2_sel_n, in3_sel, uart_sel_n, ctl_wr;
  logic sync_n, mute_n, slave_rst_n, led_green, led_red;
  logic [1:0] led_code;

  int checks = 0, fails = 0;
  logic [4:0] mdl = '0;
  logic mdl_prev = 0;
  bit done = 0;

  always #10 clk = ~clk;

  z80_bus_decoder u0 (.*);

  function automatic logic [8:0] exp_sel(logic [15:0] a, logic m, logic i, logic r, logic w);
    logic mc, ic;
    logic [8:0] e;
    mc = !m && i;
    ic = !i && m;
    e = '0;
    e[0] = mc && a <= 16'h7FFF;
    e[1] = mc && a >= 16'hA000 && a <= 16'hBFFF;
    e[2] = mc && a >= 16'hC000 && a <= 16'hDFFF;
    e[3] = mc && a >= 16'hE000 && a <= 16'hE3FF;
    e[4] = ic && !r && a[7:5] == 3'd0;
    e[5] = ic && !r && a[7:5] == 3'd1;
    e[6] = ic && !r && a[7:5] == 3'd2;
    e[7] = ic && (!r || !w) && a[7:5] == 3'd4;
    e[8] = ic && !w && a[7:5] == 3'd3;
    return e;
  endfunction

  function automatic logic [8:0] got_sel();
    return {ctl_wr, !uart_sel_n, in3_sel, !in2_sel_n, !in1_sel_n,
            !perif_req_n, !shram_req_n, !ram_sel_n, !rom_sel_n};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_latch(string req);
    chk(req, {led_code, slave_rst_n, mute_n, sync_n}, mdl);
    // R11
    chk("R11", {led_green, led_red}, {mdl[4:3] == 2'b01, mdl[4:3] == 2'b10});
  endtask

  task automatic cyc(logic [15:0] a, logic [7:0] d, logic m, logic i, logic r, logic w, string req);
    @(negedge clk);
    chk_latch("R10");
    addr = a; din = d; mreq_n = m; iorq_n = i; rd_n = r; wr_n = w;
    #2;
    chk(req, got_sel(), exp_sel(a, m, i, r, w));
    @(posedge clk);
    if (exp_sel(a, m, i, r, w)[8] && !mdl_prev) mdl = d[4:0];
    mdl_prev = exp_sel(a, m, i, r, w)[8];
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R12
    chk("R12", {sync_n, mute_n, slave_rst_n, led_code, led_green, led_red}, 0);
    @(negedge clk); rst_n = 1;
    // R2 R3 R4 R5 boundaries
    cyc(16'h0000, 0, 0, 1, 0, 1, "R2");
    cyc(16'h7FFF, 0, 0, 1, 0, 1, "R2");
    cyc(16'h8000, 0, 0, 1, 0, 1, "R5");
    cyc(16'h9FFF, 0, 0, 1, 0, 1, "R5");
    cyc(16'hA000, 0, 0, 1, 0, 1, "R3");
    cyc(16'hBFFF, 0, 0, 1, 0, 1, "R3");
    cyc(16'hC000, 0, 0, 1, 0, 1, "R4");
    cyc(16'hDFFF, 0, 0, 1, 0, 1, "R4");
    cyc(16'hE000, 0, 0, 1, 0, 1, "R5");
    cyc(16'hE3FF, 0, 0, 1, 0, 1, "R5");
    cyc(16'hE400, 0, 0, 1, 0, 1, "R5");
    cyc(16'hFFFF, 0, 0, 1, 0, 1, "R5");
    cyc(16'h1234, 0, 1, 1, 0, 1, "R1");
    cyc(16'h1234, 0, 0, 0, 0, 1, "R1");
    // R6 R7 R8 R9 ports
    cyc(16'hAB1F, 0, 1, 0, 0, 1, "R7");
    cyc(16'h0020, 0, 1, 0, 0, 1, "R7");
    cyc(16'h0040, 0, 1, 0, 0, 1, "R7");
    cyc(16'h0040, 0, 1, 0, 1, 0, "R7");
    cyc(16'h0080, 0, 1, 0, 1, 0, "R8");
    cyc(16'h0080, 0, 1, 0, 0, 1, "R8");
    cyc(16'h0080, 0, 1, 0, 1, 1, "R8");
    cyc(16'h0060, 8'hFF, 1, 0, 0, 1, "R9");
    cyc(16'hFF7F, 8'h0F, 1, 0, 1, 0, "R6");
    // R10 held strobe: only first edge loads
    cyc(16'h0060, 8'h08, 1, 0, 1, 0, "R10");
    cyc(16'h0060, 8'h17, 1, 0, 1, 0, "R10");
    cyc(16'h0060, 8'h1F, 1, 0, 1, 0, "R10");
    cyc(16'h0000, 0, 1, 1, 1, 1, "R10");
    cyc(16'h0060, 8'h18, 1, 0, 1, 0, "R11");
    cyc(16'h0000, 0, 1, 1, 1, 1, "R11");
    cyc(16'h0060, 8'h10, 1, 0, 1, 0, "R11");
    cyc(16'h0000, 0, 1, 1, 1, 1, "R11");
    void'($urandom(32'd7));
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      logic [3:0] c;
      a = $urandom;
      c = $urandom;
      if (c[3:2] == 2'b00) a[7:5] = 3'd3;
      if ($urandom_range(3) == 0) a = {3'($urandom), 13'h1FFF * 16'($urandom_range(1))};
      cyc(a, 8'($urandom), c[0], c[1] & c[3], c[2] | c[1] ? 1'b1 : 1'b0, $urandom_range(1) == 0,
          c[0] ? "R6" : "R1");
    end
    @(negedge clk);
    chk_latch("R10");
    // R12 reset mid-run
    rst_n = 0; #2;
    mdl = '0;
    chk_latch("R12");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); checks++; fails++;
        $display("FAIL watchdog act=hang exp=done"); end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule